// File: doc/BRIEF.md
# Secure Two-Way Doorbell Register Unit

This block lets an application processor and a system-control processor ring doorbells for each other. There are two channels, one per direction. Each channel holds a 32-bit status word, and each of the low 31 bits of that word is an independent doorbell. A sender rings a doorbell by writing a 1 to the channel's set register. The status bit then stays high, and the sender treats that slot as busy, until the receiver writes a 1 to the same bit of the channel's clear register. Each channel drives one interrupt toward its receiving processor.

Each processor has its own simple 32-bit register port. A port has a request strobe, a write enable, a byte address, write data and a secure-access sideband. Both ports see the same address map. Only secure accesses can change doorbells or read status. A non-secure access to a mapped register sets the top status bit of the channel it touched. That top bit is therefore reserved as a violation flag and can never act as a doorbell.

Read data is registered and appears on the cycle after the request. Interrupts are registered as well and change in the same cycle as the status they summarise.

Top module: `mbox_doorbell_top`

## Requirements
- R1: After synchronous reset both status words are zero, both interrupts are low and both read-data outputs are zero.
- R2: Address map: channel toward the application processor at base 0x200, channel toward the control processor at base 0x300; status at base+0x00, set at base+0x08, clear at base+0x10. A secure write to a set register makes every status bit 0..30 that has a 1 in the write data go high, and bits written 0 keep their value.
- R3: A secure write to a clear register makes every status bit that has a 1 in the write data go low, and bits written 0 keep their value.
- R4: When a set and a clear reach the same bit in the same cycle, possibly from the two different ports, the bit ends up set.
- R5: A write to a set register never sets bit 31.
- R6: A non-secure write to any mapped register of a channel leaves bits 0..30 of both channels unchanged and sets bit 31 of that channel.
- R7: A non-secure read of any mapped register returns zero and sets bit 31 of the accessed channel.
- R8: Bit 31 stays set until a secure write to the clear register of its own channel has a 1 in bit 31. Clearing other bits leaves it set.
- R9: The interrupt toward the application processor is high exactly when any bit 0..30 of the 0x200 channel is set. The interrupt toward the control processor follows bits 0..30 of the 0x300 channel in the same way. Bit 31 alone raises no interrupt.
- R10: Reads of set and clear registers, and any access to an unmapped offset, return zero. Unmapped accesses change no status bit and raise no flag, even when non-secure.
- R11: Read data appears one cycle after the request. It shows the status as it stood before any write issued in that same cycle, and it is zero after any cycle without a secure status read.
- R12: The two ports work concurrently. Their sets and clears in one cycle combine on a channel, and accesses to different channels do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Application port access strobe |
| a_we | input | 1 | Application port write enable |
| a_addr | input | 12 | Application port byte address |
| a_wdata | input | 32 | Application port write data |
| a_secure | input | 1 | Application port secure-access sideband |
| a_rdata | output | 32 | Application port read data, one cycle after request |
| c_req | input | 1 | Control port access strobe |
| c_we | input | 1 | Control port write enable |
| c_addr | input | 12 | Control port byte address |
| c_wdata | input | 32 | Control port write data |
| c_secure | input | 1 | Control port secure-access sideband |
| c_rdata | output | 32 | Control port read data, one cycle after request |
| irq_app | output | 1 | Doorbell interrupt toward the application processor |
| irq_ctl | output | 1 | Doorbell interrupt toward the control processor |

## Verification
Two pairs of functions can fall in the same cycle. A set and a clear can target the same doorbell of one channel. A status read can also coincide with a write that changes that status. The bench provokes the first case by having one port set a bit while the other port clears it, and it expects the bit to survive. It provokes the second case by reading a status word in the same cycle that the other port rings or clears a slot, and it expects the pre-write value back. A behavioural model compares both read-data outputs and both interrupts on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_PORTS = 2;
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_STAT = 2'd1,
    KIND_SET  = 2'd2,
    KIND_CLR  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [11:0]     BASE0    = 12'h200,
  parameter logic [11:0]     BASE1    = 12'h300,
  parameter logic [11:0]     OFF_STAT = 12'h000,
  parameter logic [11:0]     OFF_SET  = 12'h008,
  parameter logic [11:0]     OFF_CLR  = 12'h010
) (
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic                            secure_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]   set_mask_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]   clr_mask_o,
  output logic [NUM_CH-1:0]               ns_hit_o,
  output logic                            rd_en_o,
  output logic [CH_W-1:0]                 rd_ch_o
);
  localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [NUM_CH-1:0] rd_hit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE   = (ch == 0) ? ADDR_W'(BASE0) : ADDR_W'(BASE1);
    localparam logic [ADDR_W-1:0] A_STAT = BASE + ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_SET  = BASE + ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = BASE + ADDR_W'(OFF_CLR);

    reg_kind_e kind;

    always_comb begin
      if (addr_i == A_STAT)      kind = KIND_STAT;
      else if (addr_i == A_SET)  kind = KIND_SET;
      else if (addr_i == A_CLR)  kind = KIND_CLR;
      else                       kind = KIND_NONE;
    end

    always_comb begin
      set_mask_o[ch] = '0;
      clr_mask_o[ch] = '0;
      ns_hit_o[ch]   = 1'b0;
      rd_hit[ch]     = 1'b0;
      if (req_i && kind != KIND_NONE) begin
        if (!secure_i) begin
          ns_hit_o[ch] = 1'b1;
        end else if (we_i) begin
          if (kind == KIND_SET) set_mask_o[ch] = wdata_i & SLOT_MASK;
          if (kind == KIND_CLR) clr_mask_o[ch] = wdata_i;
        end else begin
          rd_hit[ch] = (kind == KIND_STAT);
        end
      end
    end
  end

  always_comb begin
    rd_en_o = |rd_hit;
    rd_ch_o = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (rd_hit[ch]) rd_ch_o = CH_W'(ch);
  end
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   set_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   clr_i,
  input  logic [NUM_PORTS-1:0]               ns_i,
  output logic [DATA_W-1:0]                  stat_o,
  output logic                               irq_o
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] set_all, clr_all, stat_q, stat_d;
  logic              ns_any;

  always_comb begin
    set_all = '0;
    clr_all = '0;
    ns_any  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_all = set_all | (set_i[p] & SLOT_MASK);
      clr_all = clr_all | clr_i[p];
      ns_any  = ns_any | ns_i[p];
    end
    stat_d = (stat_q & ~clr_all) | set_all;
    if (ns_any) stat_d[MSB] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_o  <= |stat_d[MSB-1:0];
    end
  end

  assign stat_o = stat_q;

  // R6
  ns_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ns_any |=> stat_q[MSB]);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q[MSB] && !clr_all[MSB]) |=> stat_q[MSB]);
  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_q[MSB] && !ns_any) |=> !stat_q[MSB]);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_all) |=> ((stat_q & $past(set_all)) == $past(set_all)));
  // R3
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_all & ~set_all & SLOT_MASK)) |=>
      ((stat_q & $past(clr_all & ~set_all & SLOT_MASK)) == '0));
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|stat_q[MSB-1:0]));
endmodule

// File: rtl/mbox_read_port.sv
module mbox_read_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en_i,
  input  logic [CH_W-1:0]                 rd_ch_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   stat_i,
  output logic [DATA_W-1:0]               rdata_o
);
  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= stat_i[rd_ch_i];
    else              rdata_o <= '0;
  end
endmodule

// File: rtl/mbox_doorbell_top.sv
module mbox_doorbell_top
  import mbox_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [11:0] APP_BASE = 12'h200,
  parameter logic [11:0] CTL_BASE = 12'h300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_secure,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              c_req,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  input  logic              c_secure,
  output logic [DATA_W-1:0] c_rdata,
  output logic              irq_app,
  output logic              irq_ctl
);
  logic [NUM_PORTS-1:0]                           p_req, p_we, p_sec, p_rd_en;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]               p_addr;
  logic [NUM_PORTS-1:0][DATA_W-1:0]               p_wdata, p_rdata;
  logic [NUM_PORTS-1:0][CH_W-1:0]                 p_rd_ch;
  logic [NUM_PORTS-1:0][NUM_CH-1:0][DATA_W-1:0]   p_set, p_clr;
  logic [NUM_PORTS-1:0][NUM_CH-1:0]               p_ns;
  logic [NUM_CH-1:0][NUM_PORTS-1:0][DATA_W-1:0]   c_set, c_clr;
  logic [NUM_CH-1:0][NUM_PORTS-1:0]               c_ns;
  logic [NUM_CH-1:0][DATA_W-1:0]                  ch_stat;
  logic [NUM_CH-1:0]                              ch_irq;

  assign p_req   = {c_req, a_req};
  assign p_we    = {c_we, a_we};
  assign p_sec   = {c_secure, a_secure};
  assign p_addr  = {c_addr, a_addr};
  assign p_wdata = {c_wdata, a_wdata};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbox_port_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .BASE0(APP_BASE), .BASE1(CTL_BASE)
    ) u_dec (
      .req_i(p_req[p]), .we_i(p_we[p]), .addr_i(p_addr[p]),
      .wdata_i(p_wdata[p]), .secure_i(p_sec[p]),
      .set_mask_o(p_set[p]), .clr_mask_o(p_clr[p]), .ns_hit_o(p_ns[p]),
      .rd_en_o(p_rd_en[p]), .rd_ch_o(p_rd_ch[p])
    );

    mbox_read_port #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst(rst), .rd_en_i(p_rd_en[p]), .rd_ch_i(p_rd_ch[p]),
      .stat_i(ch_stat), .rdata_o(p_rdata[p])
    );

    // R7
    ns_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (p_req[p] && !p_we[p] && !p_sec[p]) |=> (p_rdata[p] == '0));
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_xp
      assign c_set[ch][p] = p_set[p][ch];
      assign c_clr[ch][p] = p_clr[p][ch];
      assign c_ns[ch][p]  = p_ns[p][ch];
    end

    mbox_channel #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst(rst), .set_i(c_set[ch]), .clr_i(c_clr[ch]),
      .ns_i(c_ns[ch]), .stat_o(ch_stat[ch]), .irq_o(ch_irq[ch])
    );
  end

  assign a_rdata = p_rdata[0];
  assign c_rdata = p_rdata[1];
  assign irq_app = ch_irq[0];
  assign irq_ctl = ch_irq[1];
endmodule

// File: tb/mbox_doorbell_top_bench.sv
module mbox_doorbell_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_req = 0, a_we = 0, a_secure = 0;
  logic [11:0] a_addr = '0;
  logic [31:0] a_wdata = '0;
  logic        c_req = 0, c_we = 0, c_secure = 0;
  logic [11:0] c_addr = '0;
  logic [31:0] c_wdata = '0;
  logic [31:0] a_rdata, c_rdata;
  logic        irq_app, irq_ctl;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] st [2];

  always #2 clk = ~clk;

  mbox_doorbell_top u_mbox_doorbell_top (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_secure(a_secure), .a_rdata(a_rdata),
    .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_secure(c_secure), .c_rdata(c_rdata),
    .irq_app(irq_app), .irq_ctl(irq_ctl)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // decode: kind 0 unmapped, 1 status, 2 set, 3 clear
  function automatic void dec(input logic [11:0] ad, output int ch, output int kind);
    int base;
    ch = 0; kind = 0;
    for (int c = 0; c < 2; c++) begin
      base = (c == 0) ? 'h200 : 'h300;
      if (ad == 12'(base))      begin ch = c; kind = 1; end
      if (ad == 12'(base + 8))  begin ch = c; kind = 2; end
      if (ad == 12'(base + 16)) begin ch = c; kind = 3; end
    end
  endfunction

  task automatic acc_a(bit we, logic [11:0] ad, logic [31:0] d, bit sec);
    a_req = 1; a_we = we; a_addr = ad; a_wdata = d; a_secure = sec;
  endtask
  task automatic acc_c(bit we, logic [11:0] ad, logic [31:0] d, bit sec);
    c_req = 1; c_we = we; c_addr = ad; c_wdata = d; c_secure = sec;
  endtask

  // one clock: model step, then compare all outputs against the model
  task automatic step(string tag);
    bit          rq [2], wr [2], sc [2];
    logic [11:0] ad [2];
    logic [31:0] wd [2], erd [2], setm [2], clrm [2];
    bit          nsf [2];
    int ch, kind;
    rq[0] = a_req; wr[0] = a_we; ad[0] = a_addr; wd[0] = a_wdata; sc[0] = a_secure;
    rq[1] = c_req; wr[1] = c_we; ad[1] = c_addr; wd[1] = c_wdata; sc[1] = c_secure;
    for (int c = 0; c < 2; c++) begin setm[c] = 0; clrm[c] = 0; nsf[c] = 0; end
    for (int p = 0; p < 2; p++) begin
      erd[p] = 0;
      if (rq[p]) begin
        dec(ad[p], ch, kind);
        if (kind != 0) begin
          if (!sc[p]) nsf[ch] = 1;
          else if (wr[p] && kind == 2) setm[ch] |= wd[p] & 32'h7fff_ffff;
          else if (wr[p] && kind == 3) clrm[ch] |= wd[p];
          else if (!wr[p] && kind == 1) erd[p] = st[ch];
        end
      end
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      st[c] = (st[c] & ~clrm[c]) | setm[c];
      if (nsf[c]) st[c][31] = 1'b1;
    end
    chk(tag, "a_rdata", a_rdata, erd[0]);
    chk(tag, "c_rdata", c_rdata, erd[1]);
    chk(tag, "irq_app", {31'd0, irq_app}, {31'd0, |st[0][30:0]});
    chk(tag, "irq_ctl", {31'd0, irq_ctl}, {31'd0, |st[1][30:0]});
    a_req = 0; a_we = 0; c_req = 0; c_we = 0;
  endtask

  // read a status word securely and check it directly
  task automatic peek(string tag, logic [11:0] ad, logic [31:0] exp);
    acc_c(0, ad, 0, 1);
    step(tag);
    chk(tag, "status", c_rdata, exp);
  endtask

  initial begin
    st[0] = 0; st[1] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1", "a_rdata", a_rdata, 0);
    chk("R1", "irq_app", {31'd0, irq_app}, 0);
    chk("R1", "irq_ctl", {31'd0, irq_ctl}, 0);
    peek("R1", 12'h200, 0);
    peek("R1", 12'h300, 0);
    // R2 set from app toward control channel
    acc_a(1, 12'h308, 32'h0000_0005, 1); step("R2");
    peek("R2", 12'h300, 32'h0000_0005);
    // R5 bit 31 via set register ignored, zeros keep value
    acc_a(1, 12'h308, 32'h8000_0002, 1); step("R5");
    peek("R5", 12'h300, 32'h0000_0007);
    // R3 clear
    acc_c(1, 12'h310, 32'h0000_0001, 1); step("R3");
    peek("R3", 12'h300, 32'h0000_0006);
    // R4 set vs clear on the same bit from both ports
    acc_a(1, 12'h308, 32'h0000_0008, 1);
    acc_c(1, 12'h310, 32'h0000_000c, 1); step("R4");
    peek("R4", 12'h300, 32'h0000_000a);
    // R12 concurrent accesses to different channels
    acc_c(1, 12'h208, 32'h4000_0010, 1);
    acc_a(1, 12'h310, 32'h0000_0002, 1); step("R12");
    peek("R12", 12'h200, 32'h4000_0010);
    peek("R12", 12'h300, 32'h0000_0008);
    // R11 read and write in the same cycle: old value returned
    acc_c(0, 12'h200, 0, 1);
    acc_a(1, 12'h210, 32'h0000_0010, 1); step("R11");
    chk("R11", "same-cycle read", c_rdata, 32'h4000_0010);
    step("R11");
    chk("R11", "idle rdata", c_rdata, 0);
    // R6 non-secure write: no doorbell change, flag raised
    acc_a(1, 12'h208, 32'h0000_00ff, 0); step("R6");
    peek("R6", 12'h200, 32'hc000_0000);
    // R9 bit 31 alone raises no interrupt
    acc_a(1, 12'h210, 32'h4000_0000, 1); step("R9");
    chk("R9", "irq_app flag only", {31'd0, irq_app}, 0);
    peek("R9", 12'h200, 32'h8000_0000);
    // R7 non-secure read returns zero and flags
    acc_a(0, 12'h300, 0, 0); step("R7");
    chk("R7", "ns read", a_rdata, 0);
    peek("R7", 12'h300, 32'h8000_0008);
    // R8 clearing other bits keeps flag; clearing bit 31 removes it
    acc_c(1, 12'h310, 32'h7fff_ffff, 1); step("R8");
    peek("R8", 12'h300, 32'h8000_0000);
    acc_c(1, 12'h310, 32'h8000_0000, 1); step("R8");
    peek("R8", 12'h300, 32'h0000_0000);
    // R10 reads of set, clear, unmapped; unmapped writes ignored
    acc_a(1, 12'h308, 32'h0000_0100, 1); step("R10");
    acc_a(0, 12'h308, 0, 1); acc_c(0, 12'h310, 0, 1); step("R10");
    chk("R10", "set read", a_rdata, 0);
    chk("R10", "clear read", c_rdata, 0);
    acc_a(1, 12'h304, 32'hffff_ffff, 1); acc_c(0, 12'h304, 0, 0); step("R10");
    acc_a(1, 12'h314, 32'hffff_ffff, 0); step("R10");
    peek("R10", 12'h300, 32'h0000_0100);
    peek("R10", 12'h200, 32'h8000_0000);
    // R9 interrupt drops when last doorbell cleared
    acc_c(1, 12'h310, 32'h0000_0100, 1); step("R9");
    chk("R9", "irq_ctl low", {31'd0, irq_ctl}, 0);
    repeat (3) step("R11");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule